// File: doc/BRIEF.md
# Wavetable RAM DMA Engine

This engine copies a block of bytes between a system-side byte stream and local wavetable RAM. A host programs a control byte, a 16-bit start word in 16-byte paragraphs and an extension byte whose low nibble refines the start to byte granularity. It then raises a request. The system DMA side answers with a go pulse that carries an element count and a terminal-count flag. Bytes then move one per handshake. The upload direction takes bytes from the `up_*` stream into RAM. The download direction takes bytes from RAM to the `dn_*` stream. The RAM address rises by one for each byte.

On a 16-bit channel, selected by the `chan16` input, the paragraph address is remapped and every element is two bytes. On upload the engine can flip the sign bit of each sample. When a block ends, the start word and nibble advance by the element count. At terminal count the request bit drops and an optional interrupt is latched. Reading the control byte returns and then clears that pending flag.

Top module: `wtram_dma`

## Requirements
- R1: After reset the control byte, start word and extension byte read 0, and `dma_req`, `irq` and `busy` are low.
- R2: `dma_req` equals bit 0 of the control byte. Host selects are: 0 = control, 1 = start word, 2 = extension byte.
- R3: On an 8-bit channel, byte k of a block goes to RAM address {start, ext[3:0]} + k.
- R4: On a 16-bit channel the base becomes (A AND 0xC0000) + 2*(A AND 0x1FFF0), where A = {start, ext[3:0]}. A block of N elements moves 2N bytes.
- R5: Control bit 1 = 0 uploads: `up_ready` is high, and each accepted byte is written with `ram_we`. Bit 1 = 1 downloads: `dn_valid` is high and `dn_data` equals `ram_rdata` unchanged, whatever bits 6 and 7 hold.
- R6: On upload with control bit 7 set, bit 7 of a byte is inverted as follows. On an 8-bit channel, every byte is inverted unless control bit 6 is set. On a 16-bit channel, odd bytes are always inverted, and even bytes are inverted unless bit 6 is set.
- R7: When a block ends, start becomes start + (N >> 4) and the extension byte becomes (ext[3:0] + N) AND 0xF, with its upper nibble zero. No carry passes from the nibble into start.
- R8: If the go pulse carried terminal count, control bit 0 (and `dma_req`) clears when the block ends. Otherwise bit 0 is kept.
- R9: At terminal count with control bit 5 set, `irq` goes high.
- R10: A control read returns bit 6 set while `irq` is pending, and bit 2 set on a 16-bit channel. The read then clears `irq` and control bits 2 and 6.
- R11: Writing the start word clears bits 7:4 of the extension byte.
- R12: A go pulse that arrives while a block is in progress has no effect.
- R13: A block of zero elements moves no bytes. It still completes two cycles after go and applies R7 to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan16 | input | 1 | System channel is 16-bit |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (side effects at clock edge) |
| host_sel | input | 2 | Register select: 0 control, 1 start, 2 extension |
| host_wdata | input | START_W | Host write data |
| host_rdata | output | START_W | Host read data for the selected register |
| dma_req | output | 1 | Transfer request to the system DMA side |
| dma_go | input | 1 | Start pulse from the system DMA side |
| dma_count | input | CNT_W | Element count of the block |
| dma_tc | input | 1 | Block ends at terminal count |
| busy | output | 1 | Block in progress |
| up_valid | input | 1 | Upload byte valid |
| up_data | input | 8 | Upload byte |
| up_ready | output | 1 | Upload byte accepted |
| dn_valid | output | 1 | Download byte valid |
| dn_data | output | 8 | Download byte |
| dn_ready | input | 1 | Download byte taken |
| ram_addr | output | START_W+4 | Wavetable RAM byte address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data (combinational) |
| irq | output | 1 | Terminal-count interrupt pending |

## Verification
The hardest case to reach is a go pulse arriving in the middle of a block. It has to show up as nothing at all: no restart, and no other count used for the end update. The bench raises a go with a large count on the second byte of every block that has one. It then checks that the final start word and nibble match the count of the original go. A second hard case is the pairing of the sign flip with byte parity on a 16-bit channel. Table rows combine the width bit, the inversion bit and both directions, and every byte's data and address is compared.

// File: rtl/wtd_pkg.sv
package wtd_pkg;
   typedef enum logic [1:0] {MV_IDLE, MV_MOVE, MV_DONE} mv_state_t;

   localparam logic [1:0] SEL_CTRL  = 2'd0;
   localparam logic [1:0] SEL_START = 2'd1;
   localparam logic [1:0] SEL_EXT   = 2'd2;

   localparam int CB_REQ    = 0;
   localparam int CB_DIR    = 1;
   localparam int CB_W16    = 2;
   localparam int CB_TCIE   = 5;
   localparam int CB_DATA16 = 6;
   localparam int CB_INV    = 7;
endpackage

// File: rtl/wtd_xlate.sv
module wtd_xlate #(
   parameter int START_W    = 16,
   parameter int NIB_W      = 4,
   parameter bit WIDE_XLATE = 1'b1
) (
   input  logic [START_W-1:0]       start,
   input  logic [NIB_W-1:0]         nib,
   input  logic                     chan16,
   output logic [START_W+NIB_W-1:0] base
);
   localparam int AW = START_W + NIB_W;
   localparam logic [AW-1:0] ONE     = {{(AW-1){1'b0}}, 1'b1};
   localparam logic [AW-1:0] HI_MASK = {2'b11, {(AW-2){1'b0}}};
   localparam logic [AW-1:0] LO_MASK = ((ONE << (AW-3)) - ONE) & ~((ONE << NIB_W) - ONE);

   logic [AW-1:0] raw;
   assign raw = {start, nib};

   generate
      if (WIDE_XLATE) begin : g_wide
         logic [AW-1:0] remap;
         assign remap = (raw & HI_MASK) + ((raw & LO_MASK) << 1);
         assign base  = chan16 ? remap : raw;
      end else begin : g_flat
         logic unused_w;
         assign unused_w = chan16;
         assign base     = raw;
      end
   endgenerate
endmodule

// File: rtl/wtd_mover.sv
module wtd_mover
   import wtd_pkg::*;
#(
   parameter int AW    = 20,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [CNT_W-1:0] count,
   input  logic             tc_in,
   input  logic             chan16,
   input  logic [AW-1:0]    base,
   input  logic             dir_dn,
   input  logic             inv_en,
   input  logic             data16,
   input  logic             up_valid,
   input  logic [7:0]       up_data,
   output logic             up_ready,
   output logic             dn_valid,
   output logic [7:0]       dn_data,
   input  logic             dn_ready,
   output logic [AW-1:0]    ram_addr,
   output logic             ram_we,
   output logic [7:0]       ram_wdata,
   input  logic [7:0]       ram_rdata,
   output logic             busy,
   output logic             done,
   output logic [CNT_W-1:0] done_count,
   output logic             done_tc
);
   localparam int TOT_W = CNT_W + 1;
   localparam logic [TOT_W-1:0] T_ONE = {{(TOT_W-1){1'b0}}, 1'b1};

   mv_state_t        st_q;
   logic [AW-1:0]    base_q;
   logic [TOT_W-1:0] tot_q, idx_q, tot_d;
   logic [CNT_W-1:0] cnt_q;
   logic             tc_q, wide_q, fire, flip;

   assign tot_d = chan16 ? {count, 1'b0} : {1'b0, count};

   assign up_ready = (st_q == MV_MOVE) && !dir_dn;
   assign dn_valid = (st_q == MV_MOVE) && dir_dn;
   assign fire     = dir_dn ? (dn_valid && dn_ready) : (up_valid && up_ready);

   assign flip      = inv_en && !dir_dn && ((wide_q && idx_q[0]) || !data16);
   assign ram_addr  = base_q + AW'(idx_q);
   assign ram_we    = up_valid && up_ready;
   assign ram_wdata = up_data ^ {flip, 7'b0};
   assign dn_data   = ram_rdata;

   assign busy       = (st_q != MV_IDLE);
   assign done       = (st_q == MV_DONE);
   assign done_count = cnt_q;
   assign done_tc    = tc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= MV_IDLE;
         base_q <= '0;
         tot_q  <= '0;
         idx_q  <= '0;
         cnt_q  <= '0;
         tc_q   <= 1'b0;
         wide_q <= 1'b0;
      end else begin
         case (st_q)
            MV_IDLE: if (go) begin
               base_q <= base;
               tot_q  <= tot_d;
               idx_q  <= '0;
               cnt_q  <= count;
               tc_q   <= tc_in;
               wide_q <= chan16;
               st_q   <= (tot_d == '0) ? MV_DONE : MV_MOVE;
            end
            MV_MOVE: if (fire) begin
               idx_q <= idx_q + T_ONE;
               if (idx_q == tot_q - T_ONE) st_q <= MV_DONE;
            end
            default: st_q <= MV_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/wtd_regs.sv
module wtd_regs
   import wtd_pkg::*;
#(
   parameter int START_W = 16,
   parameter int CNT_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_wr,
   input  logic               host_rd,
   input  logic [1:0]         host_sel,
   input  logic [START_W-1:0] host_wdata,
   output logic [START_W-1:0] host_rdata,
   input  logic               chan16,
   input  logic               done,
   input  logic [CNT_W-1:0]   done_count,
   input  logic               done_tc,
   output logic [7:0]         ctrl_q,
   output logic [START_W-1:0] start_q,
   output logic [7:0]         ext_q,
   output logic               irq
);
   logic       pend_q;
   logic [7:0] ctrl_view;
   logic [3:0] nib_sum;

   assign nib_sum = ext_q[3:0] + done_count[3:0];
   assign irq     = pend_q;

   always_comb begin
      ctrl_view            = ctrl_q;
      ctrl_view[CB_W16]    = ctrl_q[CB_W16] | chan16;
      ctrl_view[CB_DATA16] = ctrl_q[CB_DATA16] | pend_q;
   end

   always_comb begin
      case (host_sel)
         SEL_CTRL:  host_rdata = START_W'(ctrl_view);
         SEL_START: host_rdata = start_q;
         SEL_EXT:   host_rdata = START_W'(ext_q);
         default:   host_rdata = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         start_q <= '0;
         ext_q   <= '0;
         pend_q  <= 1'b0;
      end else begin
         if (host_wr) begin
            case (host_sel)
               SEL_CTRL:  ctrl_q <= host_wdata[7:0];
               SEL_START: begin
                  start_q <= host_wdata;
                  ext_q   <= {4'h0, ext_q[3:0]};
               end
               SEL_EXT:   ext_q <= host_wdata[7:0];
               default:   ;
            endcase
         end
         if (host_rd && host_sel == SEL_CTRL) begin
            ctrl_q[CB_W16]    <= 1'b0;
            ctrl_q[CB_DATA16] <= 1'b0;
            pend_q            <= 1'b0;
         end
         if (done) begin
            start_q <= start_q + START_W'(done_count >> 4);
            ext_q   <= {4'h0, nib_sum};
            if (done_tc) begin
               ctrl_q[CB_REQ] <= 1'b0;
               if (ctrl_q[CB_TCIE]) pend_q <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/wtram_dma.sv
module wtram_dma
   import wtd_pkg::*;
#(
   parameter int START_W    = 16,
   parameter int CNT_W      = 16,
   parameter bit WIDE_XLATE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 chan16,
   input  logic                 host_wr,
   input  logic                 host_rd,
   input  logic [1:0]           host_sel,
   input  logic [START_W-1:0]   host_wdata,
   output logic [START_W-1:0]   host_rdata,
   output logic                 dma_req,
   input  logic                 dma_go,
   input  logic [CNT_W-1:0]     dma_count,
   input  logic                 dma_tc,
   output logic                 busy,
   input  logic                 up_valid,
   input  logic [7:0]           up_data,
   output logic                 up_ready,
   output logic                 dn_valid,
   output logic [7:0]           dn_data,
   input  logic                 dn_ready,
   output logic [START_W+3:0]   ram_addr,
   output logic                 ram_we,
   output logic [7:0]           ram_wdata,
   input  logic [7:0]           ram_rdata,
   output logic                 irq
);
   localparam int NIB_W = 4;
   localparam int AW    = START_W + NIB_W;

   if (START_W < 8) begin : g_bad_start
      $error("wtram_dma: START_W must be at least 8");
   end
   if (CNT_W < 4) begin : g_bad_cnt
      $error("wtram_dma: CNT_W must be at least 4");
   end

   logic [7:0]         ctrl_q, ext_q;
   logic [START_W-1:0] start_q;
   logic [AW-1:0]      base;
   logic               done, done_tc;
   logic [CNT_W-1:0]   done_count;

   assign dma_req = ctrl_q[CB_REQ];

   wtd_regs #(.START_W(START_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .chan16(chan16), .done(done), .done_count(done_count), .done_tc(done_tc),
      .ctrl_q(ctrl_q), .start_q(start_q), .ext_q(ext_q), .irq(irq)
   );

   wtd_xlate #(.START_W(START_W), .NIB_W(NIB_W), .WIDE_XLATE(WIDE_XLATE)) u_xlate (
      .start(start_q), .nib(ext_q[3:0]), .chan16(chan16), .base(base)
   );

   wtd_mover #(.AW(AW), .CNT_W(CNT_W)) u_mover (
      .clk(clk), .rst_n(rst_n),
      .go(dma_go), .count(dma_count), .tc_in(dma_tc), .chan16(chan16), .base(base),
      .dir_dn(ctrl_q[CB_DIR]), .inv_en(ctrl_q[CB_INV]), .data16(ctrl_q[CB_DATA16]),
      .up_valid(up_valid), .up_data(up_data), .up_ready(up_ready),
      .dn_valid(dn_valid), .dn_data(dn_data), .dn_ready(dn_ready),
      .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
      .busy(busy), .done(done), .done_count(done_count), .done_tc(done_tc)
   );
endmodule

// File: rtl/wtram_dma_chk.sv
module wtram_dma_chk #(
   parameter int AW = 20
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          irq,
   input logic          dma_req,
   input logic          up_ready,
   input logic          dn_valid,
   input logic          ram_we,
   input logic [AW-1:0] ram_addr,
   input logic          host_rd,
   input logic          host_wr,
   input logic [1:0]    host_sel
);
   a_r5_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
      !(up_ready && dn_valid));

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ram_we && !dn_valid && !up_ready));

   a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && $past(ram_we)) |-> (ram_addr == $past(ram_addr) + 1'b1));

   a_r9_irq_after_block: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(busy));

   a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_sel == 2'd0 && !busy) |=> !irq);

   a_r8_req_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dma_req) |-> ($past(busy) || $past(host_wr && host_sel == 2'd0)));
endmodule

bind wtram_dma wtram_dma_chk #(.AW(START_W + 4)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .irq(irq), .dma_req(dma_req),
   .up_ready(up_ready), .dn_valid(dn_valid), .ram_we(ram_we), .ram_addr(ram_addr),
   .host_rd(host_rd), .host_wr(host_wr), .host_sel(host_sel)
);

// File: tb/wtram_dma_bench.sv
module wtram_dma_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chan16 = 1'b0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [1:0]  host_sel = 2'd0;
   logic [15:0] host_wdata = '0, host_rdata;
   logic        dma_req, dma_go = 1'b0, dma_tc = 1'b0, busy;
   logic [15:0] dma_count = '0;
   logic        up_valid = 1'b0, up_ready, dn_valid, dn_ready = 1'b0;
   logic [7:0]  up_data = '0, dn_data, ram_wdata, ram_rdata;
   logic [19:0] ram_addr;
   logic        ram_we, irq;

   int n_chk = 0, n_err = 0;

   always #4 clk = ~clk;

   assign ram_rdata = ram_addr[7:0] ^ ram_addr[15:8] ^ 8'h5A;

   wtram_dma u_wtram_dma (
      .clk(clk), .rst_n(rst_n), .chan16(chan16),
      .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .dma_req(dma_req), .dma_go(dma_go), .dma_count(dma_count), .dma_tc(dma_tc),
      .busy(busy), .up_valid(up_valid), .up_data(up_data), .up_ready(up_ready),
      .dn_valid(dn_valid), .dn_data(dn_data), .dn_ready(dn_ready),
      .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
      .ram_rdata(ram_rdata), .irq(irq)
   );

   // ctrl, start, ext, chan16, count, tc
   localparam logic [49:0] VT [7] = '{
      {8'h21, 16'h1234, 8'h05, 1'b0, 16'd5,     1'b1},
      {8'h81, 16'h0100, 8'hF3, 1'b0, 16'd20,    1'b0},
      {8'hC1, 16'h3000, 8'h02, 1'b1, 16'd3,     1'b1},
      {8'h83, 16'hFFFF, 8'h0E, 1'b0, 16'h0023,  1'b1},
      {8'hA1, 16'hC123, 8'h01, 1'b1, 16'd4,     1'b1},
      {8'h23, 16'h0510, 8'h07, 1'b1, 16'd2,     1'b0},
      {8'h21, 16'h0040, 8'h09, 1'b0, 16'd0,     1'b1}
   };

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic hwrite(input logic [1:0] sel, input logic [15:0] d);
      @(negedge clk);
      host_sel = sel; host_wdata = d; host_wr = 1'b1;
      @(posedge clk); #1 host_wr = 1'b0;
   endtask

   task automatic hread(input logic [1:0] sel, output logic [15:0] d);
      @(negedge clk);
      host_sel = sel; host_rd = 1'b1;
      #1 d = host_rdata;
      @(posedge clk); #1 host_rd = 1'b0;
   endtask

   function automatic logic [19:0] xl(input logic [15:0] s, input logic [7:0] e, input logic w);
      logic [19:0] a;
      a = {s, e[3:0]};
      return w ? ((a & 20'hC0000) + ((a & 20'h1FFF0) << 1)) : a;
   endfunction

   task automatic run_vec(input int vi);
      logic [7:0]  c, e, cafter, exp_c;
      logic [15:0] s, n, rd;
      logic        w, tc, up, flip, pend;
      logic [19:0] base;
      logic [7:0]  d, exp_d;
      int          nb;
      {c, s, e, w, n, tc} = VT[vi];
      chan16 = w;
      hwrite(2'd1, s);
      hwrite(2'd2, {8'h0, e});
      hwrite(2'd0, {8'h0, c});
      @(negedge clk);
      check(dma_req == c[0], "R2 dma_req", dma_req, c[0]);
      dma_go = 1'b1; dma_count = n; dma_tc = tc;
      @(posedge clk); #1 dma_go = 1'b0;
      base = xl(s, e, w);
      up   = !c[1];
      nb   = w ? 2 * int'(n) : int'(n);
      for (int k = 0; k < nb; k++) begin
         @(negedge clk);
         if (k == 1) begin  // R12: stray go in mid-block
            dma_go = 1'b1; dma_count = 16'h0FF0;
         end
         if (up) begin
            d = 8'(k * 37 + vi * 11);
            up_valid = 1'b1; up_data = d;
            flip  = c[7] && ((w && k[0]) || !c[6]);
            exp_d = d ^ {flip, 7'b0};
            #1;
            check(ram_we == 1'b1, "R5 upload ram_we", ram_we, 1);
            check(ram_addr == base + 20'(k), w ? "R4 addr" : "R3 addr", ram_addr, base + 20'(k));
            check(ram_wdata == exp_d, "R6 upload data", ram_wdata, exp_d);
         end else begin
            dn_ready = 1'b1;
            #1;
            check(dn_valid == 1'b1 && up_ready == 1'b0, "R5 download valid", dn_valid, 1);
            check(ram_addr == base + 20'(k), w ? "R4 addr" : "R3 addr", ram_addr, base + 20'(k));
            check(dn_data == ram_rdata, "R5 download data", dn_data, ram_rdata);
         end
         @(posedge clk); #1;
         up_valid = 1'b0; dn_ready = 1'b0; dma_go = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      check(busy == 1'b0, "R13 block complete", busy, 0);
      cafter = tc ? (c & 8'hFE) : c;
      pend   = tc && c[5];
      check(dma_req == cafter[0], "R8 request bit", dma_req, cafter[0]);
      check(irq == pend, "R9 irq", irq, pend);
      hread(2'd1, rd);
      check(rd == s + (n >> 4), "R7 R12 start advance", rd, s + (n >> 4));
      hread(2'd2, rd);
      check(rd == {12'h0, e[3:0] + n[3:0]}, "R7 R12 nibble", rd, {12'h0, e[3:0] + n[3:0]});
      hread(2'd0, rd);
      exp_c = cafter | (w ? 8'h04 : 8'h00) | (pend ? 8'h40 : 8'h00);
      check(rd == {8'h0, exp_c}, "R10 ctrl read", rd, exp_c);
      @(negedge clk);
      check(irq == 1'b0, "R10 irq cleared", irq, 0);
      hread(2'd0, rd);
      exp_c = (cafter & 8'hBB) | (w ? 8'h04 : 8'h00);
      check(rd == {8'h0, exp_c}, "R10 second read", rd, exp_c);
   endtask

   initial begin
      logic [15:0] rd;
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      check(dma_req == 1'b0 && irq == 1'b0 && busy == 1'b0, "R1 reset outputs",
            {dma_req, irq, busy}, 0);
      hread(2'd0, rd); check(rd == 16'h0, "R1 ctrl reset", rd, 0);
      hread(2'd1, rd); check(rd == 16'h0, "R1 start reset", rd, 0);
      hread(2'd2, rd); check(rd == 16'h0, "R1 ext reset", rd, 0);

      hwrite(2'd2, 16'h00F7);
      hread(2'd2, rd); check(rd == 16'h00F7, "R11 ext write", rd, 16'h00F7);
      hwrite(2'd1, 16'h0042);
      hread(2'd2, rd); check(rd == 16'h0007, "R11 start write clears ext upper", rd, 16'h0007);

      for (int i = 0; i < 7; i++) run_vec(i);

      hwrite(2'd0, 16'h0001);
      @(negedge clk); check(dma_req == 1'b1, "R2 request set", dma_req, 1);
      hwrite(2'd0, 16'h0000);
      @(negedge clk); check(dma_req == 1'b0, "R2 request cleared", dma_req, 0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #(8 * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule